// File: doc/BRIEF.md
# Framer Sticky Event Status Register

This block gathers single-cycle event indications from a T3/E3 line framer and holds each one in a sticky status bit until software reads it. Three of the five events come in as pulses from detectors outside the block: zero-suppression codeword seen, framing-bit/FAS error and M-bit error. The other two come from logic inside the block. A zero-run detector watches the received bit stream and flags runs of zeros that are too long for the selected line mode. A realignment comparator watches the sync indication and the frame alignment offset, and flags when sync is regained at a new offset.

A read strobe copies the status bits into a registered 16-bit read word. In the same cycle it clears every bit whose event did not fire in that cycle. An event that coincides with a read is kept for the following read. The block produces no interrupt.

Top module: `fstat_evreg`

## Requirements
- R1: After reset every status bit is zero and `rd_data` is zero. Bits 15..5 of `rd_data` always read zero.
- R2: Bit positions in the read word: bit 0 is realignment, bit 1 is zero-suppression codeword, bit 2 is framing/FAS error, bit 3 is M-bit error and bit 4 is excessive zeros. `rd_data` takes the status in the cycle after `rd_en` is high and holds it until the next read.
- R3: A read clears every status bit whose event is not present in the read cycle. A second read with no new event returns zero.
- R4: An event that arrives in the same cycle as a read is left out of that read's data. It stays set and is returned by the next read.
- R5: With `mode_e3` = 0 (T3), the third consecutive valid zero sets bit 4, and two zeros followed by a one do not set it.
- R6: With `mode_e3` = 1 (E3), the fourth consecutive valid zero sets bit 4, and three zeros followed by a one do not set it.
- R7: A zero run raises only one excessive-zero event. After that event is read, further zeros in the same run do not set bit 4 again. A valid one ends the run.
- R8: Bit 0 sets only when `sync_ok` rises and `align_ofs` differs from the offset captured at the previous rise. The first rise after reset never sets it.
- R9: While `sync_ok` stays high, changes of `align_ofs` never set bit 0.
- R10: In E3 mode bit 3 stays zero. M-bit pulses are ignored, and a bit set earlier in T3 mode is cleared.
- R11: Bit-stream cycles with `rx_valid` = 0 neither count as zeros nor end a zero run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_e3 | input | 1 | Line mode: 0 = T3, 1 = E3 |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received data bit |
| sync_ok | input | 1 | Frame sync acquired |
| align_ofs | input | 8 | Frame alignment offset found by the framer |
| zs_code_p | input | 1 | Zero-suppression codeword pulse |
| fbit_err_p | input | 1 | Framing-bit / FAS error pulse |
| mbit_err_p | input | 1 | M-bit error pulse |
| rd_en | input | 1 | Read strobe, clears the status bits |
| rd_data | output | 16 | Registered read word |

## Verification
The bench probes zero runs exactly one bit short of the threshold in each mode. A design with an off-by-one threshold would set bit 4 there, or miss it one bit later. It continues a run after reading its event; a level-style detector would then set bit 4 again. It also inserts invalid cycles inside runs, which a detector that ignores the strobe would miscount. For realignment, the bench covers the first sync, reacquisition at the same offset, and an offset change while sync is held, each of which must leave bit 0 clear. It also fires events in the read cycle and switches to E3 with a pending M-bit flag: a design that lost the coinciding event or kept the M-bit flag would fail the following read.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  localparam int NEV       = 5;
  localparam int B_REALIGN = 0;
  localparam int B_ZSCODE  = 1;
  localparam int B_FBIT    = 2;
  localparam int B_MBIT    = 3;
  localparam int B_ZRUN    = 4;

  typedef enum logic {
    MODE_T3 = 1'b0,
    MODE_E3 = 1'b1
  } line_mode_e;
endpackage

// File: rtl/fstat_zrun.sv
module fstat_zrun #(
  parameter int T3_RUN = 3,
  parameter int E3_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_e3,
  input  logic bit_vld,
  input  logic bit_val,
  output logic zrun_p
);
  import fstat_pkg::*;

  localparam int MAXR = (T3_RUN > E3_RUN) ? T3_RUN : E3_RUN;
  localparam int CW   = $clog2(MAXR + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAXR);

  line_mode_e   mode;
  logic [CW-1:0] cnt;
  logic [CW-1:0] thr_m1;

  assign mode   = line_mode_e'(mode_e3);
  assign thr_m1 = (mode == MODE_E3) ? CW'(E3_RUN - 1) : CW'(T3_RUN - 1);

  // Pulse on the zero that brings the run to the threshold.
  assign zrun_p = bit_vld && !bit_val && (cnt == thr_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (bit_vld) begin
      if (bit_val)          cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end
  end

  // R7: one event per run, so two events can never sit back to back.
  a_r7_single_per_run: assert property (@(posedge clk) disable iff (rst)
    zrun_p |=> !zrun_p);
endmodule

// File: rtl/fstat_realign.sv
module fstat_realign #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_ok,
  input  logic [AW-1:0] align_ofs,
  output logic          realign_p
);
  logic          sync_q;
  logic          seen;
  logic [AW-1:0] last_ofs;
  logic          acq;

  assign acq       = sync_ok && !sync_q;
  assign realign_p = acq && seen && (align_ofs != last_ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 1'b0;
      seen     <= 1'b0;
      last_ofs <= '0;
    end else begin
      sync_q <= sync_ok;
      if (acq) begin
        seen     <= 1'b1;
        last_ofs <= align_ofs;
      end
    end
  end

  // R9: no realignment while sync has been held over two cycles.
  a_r9_held_sync: assert property (@(posedge clk) disable iff (rst)
    (sync_ok && $past(sync_ok)) |-> !realign_p);
  // R8: a realignment always leaves a captured alignment behind.
  a_r8_has_prev: assert property (@(posedge clk) disable iff (rst)
    realign_p |=> (seen && last_ofs == $past(align_ofs)));
endmodule

// File: rtl/fstat_sticky.sv
module fstat_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] keep,
  input  logic         clr,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat[i] <= 1'b0;
      else if (!keep[i]) stat[i] <= 1'b0;
      else               stat[i] <= (stat[i] & ~clr) | ev[i];
    end

    // R4: an allowed event is never lost, even during a read.
    a_r4_event_kept: assert property (@(posedge clk) disable iff (rst)
      (ev[i] && keep[i]) |=> stat[i]);
    // R3: a read with no coinciding event leaves the bit clear.
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
      (clr && !ev[i]) |=> !stat[i]);
  end
endmodule

// File: rtl/fstat_evreg.sv
module fstat_evreg #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int T3_RUN = 3,
  parameter int E3_RUN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_e3,
  input  logic          rx_valid,
  input  logic          rx_bit,
  input  logic          sync_ok,
  input  logic [AW-1:0] align_ofs,
  input  logic          zs_code_p,
  input  logic          fbit_err_p,
  input  logic          mbit_err_p,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  import fstat_pkg::*;

  localparam int PADW = DW - NEV;

  logic           zrun_p;
  logic           realign_p;
  logic [NEV-1:0] ev;
  logic [NEV-1:0] keep;
  logic [NEV-1:0] stat;

  fstat_zrun #(.T3_RUN(T3_RUN), .E3_RUN(E3_RUN)) zrun_i (
    .clk(clk), .rst(rst), .mode_e3(mode_e3),
    .bit_vld(rx_valid), .bit_val(rx_bit), .zrun_p(zrun_p)
  );

  fstat_realign #(.AW(AW)) realign_i (
    .clk(clk), .rst(rst), .sync_ok(sync_ok),
    .align_ofs(align_ofs), .realign_p(realign_p)
  );

  always_comb begin
    ev            = '0;
    ev[B_REALIGN] = realign_p;
    ev[B_ZSCODE]  = zs_code_p;
    ev[B_FBIT]    = fbit_err_p;
    ev[B_MBIT]    = mbit_err_p;
    ev[B_ZRUN]    = zrun_p;
    keep          = '1;
    keep[B_MBIT]  = !mode_e3;
  end

  fstat_sticky #(.N(NEV)) sticky_i (
    .clk(clk), .rst(rst), .ev(ev), .keep(keep), .clr(rd_en), .stat(stat)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {{PADW{1'b0}}, stat};
  end

  // R10: E3 mode leaves no M-bit flag behind.
  a_r10_e3_mbit: assert property (@(posedge clk) disable iff (rst)
    mode_e3 |=> !stat[B_MBIT]);
  // R2: with no read the returned word is held.
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/fstat_evreg_tb_top.sv
`timescale 1ns/1ps
module fstat_evreg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_e3 = 1'b0, rx_valid = 1'b0, rx_bit = 1'b1, sync_ok = 1'b0;
  logic [7:0]  align_ofs = '0;
  logic        zs_code_p = 1'b0, fbit_err_p = 1'b0, mbit_err_p = 1'b0, rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_q = 1'b0;
  int total = 0, bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  fstat_evreg dut_i (
    .clk(clk), .rst(rst), .mode_e3(mode_e3), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .sync_ok(sync_ok), .align_ofs(align_ofs),
    .zs_code_p(zs_code_p), .fbit_err_p(fbit_err_p), .mbit_err_p(mbit_err_p),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side: queue the expected read word, then strobe the read.
  task automatic rd(input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send(input logic b);
    rx_valid = 1'b1; rx_bit = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic idle(input int n, input logic b);
    rx_valid = 1'b0; rx_bit = b;
    repeat (n) @(negedge clk);
    rx_bit = 1'b1;
  endtask

  task automatic sync_to(input logic on, input logic [7:0] ofs);
    sync_ok = on; align_ofs = ofs;
    @(negedge clk);
  endtask

  // Monitor side: the read word is valid one edge after the strobe.
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk(rd_data, 16'hxxxx, "R2 unexpected read");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data, 16'h0000, "R1 reset rd_data");
    rd(16'h0000, "R1 reset status");

    zs_code_p = 1'b1; @(negedge clk); zs_code_p = 1'b0;
    rd(16'h0002, "R2 zs code bit1");
    rd(16'h0000, "R3 cleared after read");
    fbit_err_p = 1'b1; @(negedge clk); fbit_err_p = 1'b0;
    rd(16'h0004, "R2 fbit bit2");
    mbit_err_p = 1'b1; @(negedge clk); mbit_err_p = 1'b0;
    rd(16'h0008, "R2 mbit bit3 T3");

    // R4: event coinciding with a read
    zs_code_p = 1'b1;
    rd(16'h0000, "R4 same-cycle read excludes event");
    zs_code_p = 1'b0;
    rd(16'h0002, "R4 event kept for next read");

    // R5: T3 thresholds
    send(0); send(0); send(1);
    rd(16'h0000, "R5 two zeros no event");
    send(0); send(0); send(0);
    rd(16'h0010, "R5 three zeros event");
    // R7: same run continues
    send(0); send(0); send(0); send(0);
    rd(16'h0000, "R7 no second event in run");
    send(1); send(0); send(0); send(0);
    rd(16'h0010, "R7 new run after one");

    // R11: strobe qualification
    send(1); send(0); idle(5, 1'b1); send(0); send(0);
    rd(16'h0010, "R11 invalid cycles keep run");
    send(1); idle(5, 1'b0); send(0); send(0);
    rd(16'h0000, "R11 invalid zeros not counted");

    // R6: E3 thresholds
    mode_e3 = 1'b1;
    send(1); send(0); send(0); send(0); send(1);
    rd(16'h0000, "R6 three zeros no event");
    send(0); send(0); send(0); send(0);
    rd(16'h0010, "R6 four zeros event");

    // R10: M-bit in E3
    mbit_err_p = 1'b1; @(negedge clk); mbit_err_p = 1'b0;
    rd(16'h0000, "R10 mbit ignored in E3");
    mode_e3 = 1'b0;
    send(1);
    mbit_err_p = 1'b1; @(negedge clk); mbit_err_p = 1'b0;
    mode_e3 = 1'b1; @(negedge clk);
    rd(16'h0000, "R10 pending mbit cleared in E3");
    mode_e3 = 1'b0;

    // R8 / R9: realignment
    sync_to(1'b1, 8'd5);
    rd(16'h0000, "R8 first sync no event");
    sync_to(1'b0, 8'd5); sync_to(1'b1, 8'd5);
    rd(16'h0000, "R8 same offset no event");
    sync_to(1'b0, 8'd5); sync_to(1'b1, 8'd9);
    rd(16'h0001, "R8 new offset event");
    rd(16'h0000, "R3 realign cleared");
    sync_to(1'b1, 8'd3); sync_to(1'b1, 8'd7);
    rd(16'h0000, "R9 offset change under sync");

    repeat (3) @(negedge clk);
    chk(16'(exp_q.size()), 16'h0000, "R2 all reads returned");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule